// File: doc/BRIEF.md
# Duplex-Aware Carrier Sense and Collision Logic

This block produces the carrier-sense and collision indications that an Ethernet physical layer presents on its media-independent interface, together with two control outputs for the 10 Mb/s path: an enable that asks the receive path to return transmitted data, and a request for the heartbeat (SQE) test pulse that follows each transmission. Its inputs are the duplex and speed selections, transmit-enable, a receive-activity flag from the line detector and a one-cycle strobe marking the end of each transmission.

In half duplex the block keeps the shared-medium behaviour. Carrier is sensed whenever the node is sending or receiving, and a collision is flagged whenever both happen at once. At 10 Mb/s the block also loops transmitted data back and runs the heartbeat test after each transmission. In full duplex, carrier follows receive activity alone, collision never rises, and the loopback and heartbeat functions stay off. Any change of the duplex or speed selection flushes the outputs for one cycle and abandons a heartbeat in progress.

All outputs come from registers or from registered state, so they respond one clock edge after the inputs are sampled. The heartbeat delay and width are parameters.

Top module: `duplex_carrier_sense`

## Requirements
- R1: In half duplex with no mode change, `crs_o` after a clock edge equals the OR of `tx_en_i` and `rx_act_i` sampled at that edge.
- R2: In full duplex with no mode change, `crs_o` after a clock edge equals `rx_act_i` sampled at that edge, whatever `tx_en_i` is.
- R3: Whenever the registered duplex selection is full (`full_dup_i` was 1 at the last edge), `col_o` is 0.
- R4: In half duplex with no mode change and no heartbeat pulse, `col_o` after an edge equals the AND of `tx_en_i` and `rx_act_i` sampled at that edge.
- R5: `lpbk_en_o` after an edge equals `tx_en_i` sampled at that edge only when half duplex at 10 Mb/s (`full_dup_i`=0, `spd100_i`=0) is selected and unchanged; in every other case it is 0.
- R6: A `tx_done_i` strobe sampled at edge E in 10 Mb/s half duplex with the sequencer idle makes `sqe_req_o` high from edge E+SQE_DELAY through edge E+SQE_DELAY+SQE_WIDTH-1 (SQE_WIDTH cycles), and `col_o` is high for the same cycles.
- R7: A `tx_done_i` strobe sampled in full duplex or at 100 Mb/s (`spd100_i`=1) starts no heartbeat: `sqe_req_o` stays 0.
- R8: A `tx_done_i` strobe that arrives while a heartbeat is waiting or pulsing is ignored and does not restart or extend it.
- R9: If `full_dup_i` or `spd100_i` at an edge differs from its value at the previous edge, then `crs_o`, `col_o`, `lpbk_en_o` and `sqe_req_o` are 0 after that edge, and a pending heartbeat is cancelled.
- R10: During and directly after reset all outputs are 0, and the reference mode for change detection is half duplex at 10 Mb/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_dup_i | input | 1 | 1 selects full duplex, 0 half duplex |
| spd100_i | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_act_i | input | 1 | Receive activity present on the line |
| tx_done_i | input | 1 | One-cycle strobe at the end of a transmission |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision indication, including the heartbeat pulse |
| lpbk_en_o | output | 1 | Return transmitted data to the receive path |
| sqe_req_o | output | 1 | Heartbeat test pulse request |

## Verification
The bench targets a transmit-only burst in full duplex, where a design that still ORs in transmit-enable would raise carrier falsely. It also targets an end-of-transmit strobe at 100 Mb/s or in full duplex, where a leaky gate would fire a heartbeat and a spurious collision, and a second strobe during a heartbeat, which a careless sequencer would take as a restart that stretches the pulse. Mode switches are placed in the middle of a heartbeat and of a colliding transfer. A design that failed to flush there would carry a stale collision into the new mode or let the pulse finish late.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [1:0] {
    SQE_IDLE  = 2'd0,
    SQE_WAIT  = 2'd1,
    SQE_PULSE = 2'd2
  } sqe_state_e;

  // carrier: half duplex senses both directions, full duplex only receive
  function automatic logic sense_carrier(input logic fd, input logic tx, input logic rx);
    return fd ? rx : (tx | rx);
  endfunction

  // collision is only meaningful on a shared medium
  function automatic logic sense_collision(input logic fd, input logic tx, input logic rx);
    return !fd && tx && rx;
  endfunction

  // classic 10 Mb/s half duplex is the only mode with loopback and heartbeat
  function automatic logic is_shared10(input logic fd, input logic sp);
    return !fd && !sp;
  endfunction

endpackage

// File: rtl/dcs_mode_track.sv
module dcs_mode_track (
  input  logic clk,
  input  logic rst_n,
  input  logic full_dup_i,
  input  logic spd100_i,
  output logic fd_q_o,
  output logic sp_q_o,
  output logic mode_chg_o
);

  logic fd_q, sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fd_q <= 1'b0;
      sp_q <= 1'b0;
    end else begin
      fd_q <= full_dup_i;
      sp_q <= spd100_i;
    end
  end

  assign mode_chg_o = (full_dup_i != fd_q) || (spd100_i != sp_q);
  assign fd_q_o     = fd_q;
  assign sp_q_o     = sp_q;

endmodule

// File: rtl/dcs_sense.sv
module dcs_sense
  import dcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic full_dup_i,
  input  logic spd100_i,
  input  logic mode_chg_i,
  input  logic fd_q_i,
  input  logic sp_q_i,
  input  logic tx_en_i,
  input  logic rx_act_i,
  output logic crs_q_o,
  output logic col_q_o,
  output logic lpbk_q_o
);

  logic crs_q, col_q, lpbk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || mode_chg_i) begin
      crs_q  <= 1'b0;
      col_q  <= 1'b0;
      lpbk_q <= 1'b0;
    end else begin
      crs_q  <= sense_carrier(full_dup_i, tx_en_i, rx_act_i);
      col_q  <= sense_collision(full_dup_i, tx_en_i, rx_act_i);
      lpbk_q <= is_shared10(full_dup_i, spd100_i) && tx_en_i;
    end
  end

  assign crs_q_o  = crs_q;
  assign col_q_o  = col_q;
  assign lpbk_q_o = lpbk_q;

  // R3: data-path collision never seen while full duplex is registered
  a_r3_fd_col_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fd_q_i |-> !col_q);

  // R5: loopback only in 10 Mb/s half duplex
  a_r5_lpbk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_q_i || sp_q_i) |-> !lpbk_q);

  // R2: full duplex carrier ignores transmit
  a_r2_fd_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
    (full_dup_i && !mode_chg_i && tx_en_i && !rx_act_i) |=> !crs_q);

endmodule

// File: rtl/dcs_sqe_seq.sv
module dcs_sqe_seq
  import dcs_pkg::*;
#(
  parameter int SQE_DELAY = 4,
  parameter int SQE_WIDTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic full_dup_i,
  input  logic spd100_i,
  input  logic mode_chg_i,
  input  logic fd_q_i,
  input  logic sp_q_i,
  input  logic tx_done_i,
  output logic sqe_req_o
);

  localparam int MAXC = (SQE_DELAY > SQE_WIDTH) ? SQE_DELAY : SQE_WIDTH;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  sqe_state_e    state;
  logic [CW-1:0] cnt;
  logic          arm;
  logic          cnt_zero;

  // a strobe starts a heartbeat only in 10 Mb/s half duplex and when idle
  assign arm      = tx_done_i && is_shared10(full_dup_i, spd100_i) && (state == SQE_IDLE);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || mode_chg_i) begin
      state <= SQE_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SQE_IDLE: if (arm) begin
          state <= SQE_WAIT;
          cnt   <= CW'(SQE_DELAY - 1);
        end
        SQE_WAIT: if (cnt_zero) begin
          state <= SQE_PULSE;
          cnt   <= CW'(SQE_WIDTH - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        SQE_PULSE: if (cnt_zero) begin
          state <= SQE_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= SQE_IDLE;
      endcase
    end
  end

  assign sqe_req_o = (state == SQE_PULSE);

  // R7: no heartbeat in full duplex or at 100 Mb/s
  a_r7_sqe_mode_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_q_i || sp_q_i) |-> (state == SQE_IDLE));

  // R6: a pulse is always preceded by the wait phase
  a_r6_pulse_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqe_req_o) |-> $past(state == SQE_WAIT));

  // R8: a strobe during an active sequence does not return to the wait start
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQE_PULSE && !mode_chg_i && !cnt_zero) |=> (state == SQE_PULSE));

endmodule

// File: rtl/duplex_carrier_sense.sv
module duplex_carrier_sense #(
  parameter int SQE_DELAY = 4,
  parameter int SQE_WIDTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic full_dup_i,
  input  logic spd100_i,
  input  logic tx_en_i,
  input  logic rx_act_i,
  input  logic tx_done_i,
  output logic crs_o,
  output logic col_o,
  output logic lpbk_en_o,
  output logic sqe_req_o
);

  logic fd_q, sp_q, mode_chg;
  logic crs_q, col_q, lpbk_q, sqe_pulse;

  dcs_mode_track u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_dup_i (full_dup_i),
    .spd100_i   (spd100_i),
    .fd_q_o     (fd_q),
    .sp_q_o     (sp_q),
    .mode_chg_o (mode_chg)
  );

  dcs_sense u_sense (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_dup_i (full_dup_i),
    .spd100_i   (spd100_i),
    .mode_chg_i (mode_chg),
    .fd_q_i     (fd_q),
    .sp_q_i     (sp_q),
    .tx_en_i    (tx_en_i),
    .rx_act_i   (rx_act_i),
    .crs_q_o    (crs_q),
    .col_q_o    (col_q),
    .lpbk_q_o   (lpbk_q)
  );

  dcs_sqe_seq #(
    .SQE_DELAY (SQE_DELAY),
    .SQE_WIDTH (SQE_WIDTH)
  ) u_sqe (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_dup_i (full_dup_i),
    .spd100_i   (spd100_i),
    .mode_chg_i (mode_chg),
    .fd_q_i     (fd_q),
    .sp_q_i     (sp_q),
    .tx_done_i  (tx_done_i),
    .sqe_req_o  (sqe_pulse)
  );

  assign crs_o     = crs_q;
  assign col_o     = col_q | sqe_pulse;
  assign lpbk_en_o = lpbk_q;
  assign sqe_req_o = sqe_pulse;

  // R3: collision pin quiet in full duplex, heartbeat included
  a_r3_col_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fd_q |-> !col_o);

  // R9: a mode switch flushes every output
  a_r9_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!crs_o && !col_o && !lpbk_en_o && !sqe_req_o));

  // R6: heartbeat request is always visible as a collision
  a_r6_sqe_on_col: assert property (@(posedge clk) disable iff (!rst_n)
    sqe_req_o |-> col_o);

endmodule

// File: tb/duplex_carrier_sense_tb.sv
module duplex_carrier_sense_tb;

  localparam int D = 4;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fd = 1'b0, sp = 1'b0, tx = 1'b0, rx = 1'b0, done = 1'b0;
  logic crs, col, lpbk, sqe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  duplex_carrier_sense #(.SQE_DELAY(D), .SQE_WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .full_dup_i(fd), .spd100_i(sp),
    .tx_en_i(tx), .rx_act_i(rx), .tx_done_i(done),
    .crs_o(crs), .col_o(col), .lpbk_en_o(lpbk), .sqe_req_o(sqe)
  );

  // bench model of the requirements
  logic m_fd = 0, m_sp = 0, m_crs = 0, m_col = 0, m_lp = 0;
  int   m_st = 0;   // 0 idle, 1 waiting, 2 pulsing
  int   m_cnt = 0;
  logic l_chg = 0;

  function automatic logic exp_crs(logic f, logic t, logic r);
    if (f) return r;
    return t || r;
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    logic chg;
    chg = (fd != m_fd) || (sp != m_sp);
    l_chg = chg;
    if (chg) begin
      m_crs = 0; m_col = 0; m_lp = 0; m_st = 0; m_cnt = 0;
    end else begin
      m_crs = exp_crs(fd, tx, rx);
      m_col = !fd && tx && rx;
      m_lp  = !fd && !sp && tx;
      case (m_st)
        0: if (!fd && !sp && done) begin m_st = 1; m_cnt = D - 1; end
        1: if (m_cnt == 0) begin m_st = 2; m_cnt = W - 1; end else m_cnt--;
        default: if (m_cnt == 0) m_st = 0; else m_cnt--;
      endcase
    end
    m_fd = fd; m_sp = sp;
  endtask

  task automatic compare();
    string tc, tl, tl2, ts;
    logic ecol;
    ecol = m_col || (m_st == 2);
    tc  = l_chg ? "R9" : (m_fd ? "R2" : "R1");
    tl  = l_chg ? "R9" : (m_st == 2 ? "R6" : (m_fd ? "R3" : "R4"));
    tl2 = l_chg ? "R9" : "R5";
    ts  = l_chg ? "R9" : ((m_fd || m_sp) ? "R7" : "R6");
    chk(tc,  crs,  m_crs,    "crs_o");
    chk(tl,  col,  ecol,     "col_o");
    chk(tl2, lpbk, m_lp,     "lpbk_en_o");
    chk(ts,  sqe,  m_st == 2, "sqe_req_o");
  endtask

  // drive at negedge, model the coming edge, compare at the next negedge
  task automatic cycle(logic f, logic s, logic t, logic r, logic d);
    fd = f; sp = s; tx = t; rx = r; done = d;
    model_step();
    @(negedge clk);
    cyc++;
    compare();
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs low while in reset
    chk("R10", crs | col | lpbk | sqe, 1'b0, "outputs in reset");
    rst_n = 1'b1;
    // R10: reference mode is half/10, so no flush after release with that mode
    cycle(0, 0, 1, 0, 0);
    chk("R10", crs, 1'b1, "crs after reset in half/10");

    // R1 / R4 / R5: half duplex 10 patterns
    cycle(0, 0, 1, 1, 0);
    cycle(0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0);
    // R6: heartbeat; R8: second strobe while waiting and while pulsing
    cycle(0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1);
    for (int i = 0; i < D + W; i++) cycle(0, 0, 0, 0, (i == D) ? 1'b1 : 1'b0);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 0);
    // R9: mode change mid-pulse
    cycle(0, 0, 0, 0, 1);
    for (int i = 0; i < D + 1; i++) cycle(0, 0, 1, 1, 0);
    cycle(1, 0, 1, 1, 0);
    chk("R9", col, 1'b0, "col after switch mid-pulse");
    // R2 / R3: full duplex transmit only, collision-like traffic
    cycle(1, 0, 1, 0, 0);
    chk("R2", crs, 1'b0, "fd transmit-only crs");
    cycle(1, 0, 1, 1, 1);
    for (int i = 0; i < D + W + 2; i++) cycle(1, 0, 1, 1, 0);
    // R7: 100 Mb/s half duplex strobe, loopback off
    cycle(0, 1, 1, 1, 0);
    cycle(0, 1, 1, 0, 1);
    for (int i = 0; i < D + W + 2; i++) cycle(0, 1, 1, 0, 0);
    cycle(0, 0, 0, 0, 0);

    // random mix
    void'($urandom(32'h5eed_2024));
    for (int i = 0; i < 4000; i++) begin
      logic nf, ns;
      nf = fd; ns = sp;
      if ($urandom_range(63) == 0) nf = $urandom_range(1);
      if ($urandom_range(63) == 0) ns = $urandom_range(1);
      cycle(nf, ns, 1'($urandom_range(1)), 1'($urandom_range(1)),
            ($urandom_range(7) == 0) ? 1'b1 : 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule